// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A small up-counter, four bits wide by default, that can be cleared at any moment, preset from a parallel data word, and counted up by one on each rising clock edge when two enables are both high. The two enables are not equivalent. `en_par` gates counting alone. `en_chain` gates counting and also qualifies the terminal-count flag `tc`. `tc` is high when `en_chain` is high and the count is at its maximum value.

Stages are chained into a wider synchronous counter. All stages share the clock, the clear and `en_par`. Each stage's `tc` drives the `en_chain` input of the stage above it. Every stage therefore decides on the same edge. The upper stage advances once for each full cycle of the lower stage.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 and `tc` is 0, whatever `preset_n`, `en_par`, `en_chain` and `din` are.
- R2: Clear is asynchronous. A falling `clr_n` between clock edges drives `q` to 0 at once, with no rising edge needed.
- R3: With `clr_n` high and `preset_n` low, the next rising edge copies `din` into `q`, for any value of the two enables.
- R4: With `clr_n` and `preset_n` high and both `en_par` and `en_chain` high, each rising edge adds one to `q`.
- R5: With `clr_n` and `preset_n` high, `q` keeps its value across a rising edge if either enable is low.
- R6: Counting wraps from the maximum value (15 at the default width) back to 0.
- R7: `tc` is high exactly when `en_chain` is high and `q` is at its maximum. It ignores `en_par`, and it follows a change on `en_chain` within the same cycle.
- R8: In a chain of two stages, the upper stage advances once per 16 counts of the lower stage, on the edge where the lower stage wraps.
- R9: On the first rising edge after `clr_n` returns high, the counter makes the normal preset, count or hold decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| preset_n | input | 1 | Synchronous parallel preset, active low |
| en_par | input | 1 | Count enable that does not reach `tc` |
| en_chain | input | 1 | Count enable that also qualifies `tc` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: `en_chain` and count at maximum |

## Verification
Preset, count and hold results appear in `q` at the first rising edge after the inputs are presented. The bench drives its inputs just after a falling edge and compares at the following falling edge, one full register stage later. `tc` is combinational, so the bench checks it after a short delay inside the same cycle, with no edge in between. Clear is checked a nanosecond after `clr_n` falls in the middle of a cycle. The reference model updates on each rising edge and is compared with both chained stages at every falling edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_COUNT  = 2'd1,
        MODE_PRESET = 2'd2
    } ctr_mode_e;

    // Preset wins over counting; counting needs both enables.
    function automatic ctr_mode_e pick_mode(input logic preset_n,
                                            input logic en_par,
                                            input logic en_chain);
        ctr_mode_e m;
        if (!preset_n)
            m = MODE_PRESET;
        else if (en_par && en_chain)
            m = MODE_COUNT;
        else
            m = MODE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
    import ctr_pkg::*;
(
    input  logic      preset_n,
    input  logic      en_par,
    input  logic      en_chain,
    output ctr_mode_e mode
);
    always_comb begin
        mode = pick_mode(preset_n, en_par, en_chain);
    end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (mode)
            MODE_PRESET: q_next = din;
            MODE_COUNT:  q_next = q + ONE;
            default:     q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= q_next;
    end
endmodule

// File: rtl/ctr_tc_gen.sv
module ctr_tc_gen #(
    parameter int WIDTH = 4
) (
    input  logic             en_chain,
    input  logic [WIDTH-1:0] q,
    output logic             tc
);
    logic [WIDTH:0] chain;

    assign chain[0] = en_chain;
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & q[i];
    end
    assign tc = chain[WIDTH];
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             preset_n,
    input  logic             en_par,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             tc
);
    ctr_mode_e mode;

    ctr_mode_sel u_sel (
        .preset_n (preset_n),
        .en_par   (en_par),
        .en_chain (en_chain),
        .mode     (mode)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .mode  (mode),
        .din   (din),
        .q     (q)
    );

    ctr_tc_gen #(.WIDTH(WIDTH)) u_tc (
        .en_chain (en_chain),
        .q        (q),
        .tc       (tc)
    );
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             preset_n,
    input logic             en_par,
    input logic             en_chain,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             tc
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // R1: clear holds the count and the flag at zero
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |-> (q == '0 && !tc));

    // R3: preset loads din regardless of enables
    a_r3_preset: assert property (@(posedge clk) disable iff (!clr_n)
        !preset_n |=> q == $past(din));

    // R4: both enables count up
    a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && en_par && en_chain && q != TOP) |=> q == $past(q) + 1'b1);

    // R5: a low enable holds the count
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && !(en_par && en_chain)) |=> $stable(q));

    // R6: the maximum value wraps to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && en_par && en_chain && q == TOP) |=> q == '0);

    // R7: the flag implies its enable and the top value
    a_r7_tc_cause: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (en_chain && q == TOP));
endmodule

bind cascade_counter ctr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .preset_n (preset_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .din      (din),
    .q        (q),
    .tc       (tc)
);

// File: tb/sim_cascade_counter.sv
module sim_cascade_counter;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       preset_n = 1'b1;
    logic       en_par = 1'b0;
    logic       en_chain = 1'b0;
    logic [3:0] din_lo = 4'd0;
    logic [3:0] din_hi = 4'd0;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;

    int n_cmp = 0;
    int n_bad = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_counter #(.WIDTH(4)) u0 (
        .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .en_par(en_par),
        .en_chain(en_chain), .din(din_lo), .q(q_lo), .tc(tc_lo));

    cascade_counter #(.WIDTH(4)) u1 (
        .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .en_par(en_par),
        .en_chain(tc_lo), .din(din_hi), .q(q_hi), .tc(tc_hi));

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int lo_tc;
        lo_tc = (clr_n && en_chain && m_lo == 15) ? 1 : 0;
        check({tag, " q_lo"}, int'(q_lo), m_lo);
        check({tag, " q_hi"}, int'(q_hi), m_hi);
        check({tag, " tc_lo R7"}, int'(tc_lo), lo_tc);
        check({tag, " tc_hi R7"}, int'(tc_hi), (lo_tc == 1 && m_hi == 15) ? 1 : 0);
    endtask

    // One clock: model updates on the rising edge, compare at the falling edge
    task automatic step(input string tag);
        int lo_tc_old;
        @(posedge clk);
        if (clr_n) begin
            lo_tc_old = (en_chain && m_lo == 15) ? 1 : 0;
            if (!preset_n) begin
                m_lo = int'(din_lo);
                m_hi = int'(din_hi);
            end else if (en_par) begin
                if (en_chain) m_lo = (m_lo + 1) % 16;
                if (lo_tc_old == 1) m_hi = (m_hi + 1) % 16;
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hi_prev;
        int hi_steps;
        #1 clr_n = 1'b0;
        en_par = 1'b1; en_chain = 1'b1; preset_n = 1'b0; din_lo = 4'd9;
        #1 compare_all("R1 reset state");
        step("R1 clear overrides preset");
        step("R1 clear overrides count");
        clr_n = 1'b1; preset_n = 1'b1;
        step("R9 first edge after release counts");
        check("R9 count is one", int'(q_lo), 1);

        // R3: preset with enables low and with enables high
        en_par = 1'b0; en_chain = 1'b0; preset_n = 1'b0; din_lo = 4'd6; din_hi = 4'd3;
        step("R3 preset enables low");
        en_par = 1'b1; en_chain = 1'b1; din_lo = 4'd11; din_hi = 4'd12;
        step("R3 preset enables high");
        preset_n = 1'b1;

        // R5: hold with each enable low in turn
        en_par = 1'b0;
        step("R5 hold en_par low");
        en_par = 1'b1; en_chain = 1'b0;
        step("R5 hold en_chain low");
        en_par = 1'b0;
        step("R5 hold both low");

        // R4 and R6: count through the top value
        en_par = 1'b1; en_chain = 1'b1;
        for (int i = 0; i < 6; i++) step("R4 count up");
        check("R6 wrapped past top", int'(q_lo), 1);

        // R7: flag at top value, en_chain drops within cycle, en_par ignored
        preset_n = 1'b0; din_lo = 4'd15; din_hi = 4'd2;
        step("R7 preset to top");
        preset_n = 1'b1; en_par = 1'b0;
        #1 check("R7 tc with en_par low", int'(tc_lo), 1);
        en_chain = 1'b0;
        #1 check("R7 tc follows en_chain same cycle", int'(tc_lo), 0);
        en_chain = 1'b1;
        #1 check("R7 tc back high", int'(tc_lo), 1);
        en_par = 1'b1;
        step("R6 wrap top to zero");
        check("R6 wrap value", int'(q_lo), 0);

        // R2: clear in mid-cycle with no edge
        step("R2 pre-clear count");
        #1 clr_n = 1'b0;
        #1 check("R2 q_lo zero without edge", int'(q_lo), 0);
        check("R2 q_hi zero without edge", int'(q_hi), 0);
        check("R2 tc zero without edge", int'(tc_lo), 0);
        m_lo = 0; m_hi = 0;
        @(negedge clk);
        clr_n = 1'b1;
        en_par = 1'b0;
        step("R9 hold after release");

        // R8: cascade 48 counts from zero
        en_par = 1'b1; en_chain = 1'b1;
        hi_prev = int'(q_hi);
        hi_steps = 0;
        for (int i = 0; i < 48; i++) begin
            step("R8 cascade");
            if (int'(q_hi) != hi_prev) begin
                hi_steps++;
                check("R8 upper moves on lower wrap", int'(q_lo), 0);
            end
            hi_prev = int'(q_hi);
        end
        check("R8 upper advanced three times", hi_steps, 3);
        check("R8 upper value", int'(q_hi), 3);

        // R8: full 8-bit rollover
        preset_n = 1'b0; din_lo = 4'd14; din_hi = 4'd15;
        step("R8 preset near 8-bit top");
        preset_n = 1'b1;
        step("R8 at 255");
        check("R7 upper tc at 255", int'(tc_hi), 1);
        step("R8 rollover to zero");
        check("R8 both zero", int'({q_hi, q_lo}), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule